// File: doc/BRIEF.md
# Two-Wire Register Access Target with Auto-Advancing Pointer

This block is the target side of a two-wire serial link (I2C) that gives an external controller access to a small bank of 8-bit registers. It runs on a fast system clock and samples the serial clock and data lines through synchronizers. It recognises frame boundaries, compares the 7-bit device address, and acknowledges by pulling the data line low through an output enable. The line itself is open-drain.

In a write-direction frame, the first byte after the address loads a register pointer. Each following byte is written to the register that the pointer names, and the pointer then advances. A read is done with a write-direction frame that sets the pointer, then a repeated start with the direction bit set. From there the target sends register contents MSB first and advances the pointer after each byte. The pointer keeps its value across a stop, so a later read frame picks up where the last one left off.

The pointer stops advancing once it leaves the implemented bank. Any read from that region returns a fixed filler byte. The register storage sits outside the block. It sees a one-cycle write pulse with address and data, and a one-cycle read strobe with the address of each byte loaded for sending.

Top module: `i2c_reg_target`

## Requirements
- R1: A frame opens only when SDA falls while SCL is high, and closes when SDA rises while SCL is high. Bytes clocked with no opening condition get no ACK. After reset SDA is released, and there are no write pulses and no read strobes.
- R2: A first byte whose bits [7:1] equal DEV_ADDR is acknowledged by SDA held low through the ninth SCL pulse. Bit 0 of that byte is the direction: 0 means write, 1 means read. On a mismatch the target gives no ACK and ignores every byte until the next start or stop. It writes nothing and leaves the pointer unchanged.
- R3: In a write frame, the byte after the address is loaded into the pointer and acknowledged. Each later byte is acknowledged and, if the pointer is in the bank, produces one reg_wr_en pulse with reg_wr_addr equal to the pointer and reg_wr_data equal to the byte. The pointer then advances.
- R4: After a start and an address byte with bit 0 set, the target sends the byte at the pointer, MSB first. SDA changes only while SCL is low, so every bit is stable for the whole high phase of SCL.
- R5: The pointer advances by one after each byte loaded for sending, so a multi-byte read returns consecutive registers.
- R6: A stop leaves the pointer unchanged. A read frame with no pointer byte starts at the pointer left by the previous frame, and the pointer is 0 after reset.
- R7: A pointer at or above NUM_REGS reads as DUMMY_VAL (FFh by default), repeatedly. Writes there are acknowledged but give no reg_wr_en.
- R8: Once at or above NUM_REGS, the pointer does not advance and never wraps to 0. Only a new pointer byte moves it.
- R9: After the controller answers a sent byte with NACK (SDA high on the ninth pulse), the target keeps SDA released until the next start or stop.
- R10: reg_rd_stb is a one-cycle pulse, with reg_rd_addr equal to the pointer, for each in-bank byte loaded for sending. There is none for filler bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_wr_en | output | 1 | One-cycle register write pulse |
| reg_wr_addr | output | 8 | Register address for the write |
| reg_wr_data | output | 8 | Data for the write |
| reg_rd_stb | output | 1 | One-cycle pulse when a register byte is loaded for sending |
| reg_rd_addr | output | 8 | Register address to read (the pointer) |
| reg_rd_data | input | 8 | Register contents at reg_rd_addr, combinational |

## Verification
The sweep sets the pointer to every start position from 0 up to two places past the bank, writes three bytes, and reads six back in one frame. A pointer that fails to advance, advances on the wrong event, or lets writes past the bank edge shows up in the returned sequence. Each sweep step then runs a read frame with no pointer byte. This separates a pointer that survives a stop from one that is cleared, and saturation at the bank edge from wrap-around. Separate patterns use a wrong device address, bytes clocked before any start, a NACK followed by more clocking over a register with known non-filler contents, and a pointer of FFh with further data bytes. The last pattern shows that the pointer does not wrap into register 0.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_IGNORE
  } tgt_state_t;

  // Pointer lies inside the implemented bank.
  function automatic logic ptr_in_bank(input logic [7:0] p, input logic [7:0] bank);
    return p < bank;
  endfunction

  // Advance inside the bank, hold once outside it (no wrap).
  function automatic logic [7:0] ptr_next(input logic [7:0] p, input logic [7:0] bank);
    return ptr_in_bank(p, bank) ? p + 8'd1 : p;
  endfunction

  function automatic logic addr_matches(input logic [7:0] first_byte, input logic [6:0] dev);
    return first_byte[7:1] == dev;
  endfunction

  function automatic logic [7:0] pick_tx(input logic hit, input logic [7:0] rd,
                                         input logic [7:0] filler);
    return hit ? rd : filler;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] scl_sh;
  logic [DEPTH-1:0] sda_sh;
  logic scl_d;
  logic sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_i};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_i};
    end
  end

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];
  assign scl_d = scl_sh[STAGES];
  assign sda_d = sda_sh[STAGES];

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit
  import i2c_reg_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_en,
  input  logic [7:0] set_val,
  input  logic       adv_en,
  output logic [7:0] ptr
);
  localparam logic [7:0] BANK_SZ = 8'(NUM_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= 8'd0;
    else if (set_en) ptr <= set_val;
    else if (adv_en) ptr <= ptr_next(ptr, BANK_SZ);
  end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h2A,
  parameter int unsigned NUM_REGS    = 4,
  parameter logic [7:0]  DUMMY_VAL   = 8'hFF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       reg_wr_en,
  output logic [7:0] reg_wr_addr,
  output logic [7:0] reg_wr_data,
  output logic       reg_rd_stb,
  output logic [7:0] reg_rd_addr,
  input  logic [7:0] reg_rd_data
);
  localparam logic [7:0] BANK_SZ  = 8'(NUM_REGS);
  localparam logic [3:0] BYTE_LEN = 4'd8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  tgt_state_t state, after_ack;
  logic [7:0] shreg;
  logic [3:0] bitcnt;
  logic       mack;
  logic [7:0] ptr;

  // Named internal events
  logic frame_evt, receiving, byte_done, addr_hit, ptr_set, wr_evt;
  logic load_evt, quiet, in_bank;
  logic [7:0] load_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  assign frame_evt = start_evt | stop_evt;
  assign receiving = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
  assign byte_done = receiving && scl_fall && (bitcnt == BYTE_LEN) && !frame_evt;
  assign addr_hit  = addr_matches(shreg, DEV_ADDR);
  assign ptr_set   = byte_done && (state == ST_PTR);
  assign wr_evt    = byte_done && (state == ST_WDATA);
  assign load_evt  = scl_fall && !frame_evt &&
                     (((state == ST_ACK) && (after_ack == ST_SEND)) ||
                      ((state == ST_MACK) && mack));
  assign quiet     = (state == ST_IDLE) || (state == ST_IGNORE);
  assign in_bank   = ptr_in_bank(ptr, BANK_SZ);
  assign load_val  = pick_tx(in_bank, reg_rd_data, DUMMY_VAL);

  i2c_ptr_unit #(.NUM_REGS(NUM_REGS)) u_ptr (
    .clk(clk), .rst_n(rst_n), .set_en(ptr_set), .set_val(shreg),
    .adv_en(wr_evt | load_evt), .ptr(ptr)
  );

  assign reg_wr_en   = wr_evt && in_bank;
  assign reg_wr_addr = ptr;
  assign reg_wr_data = shreg;
  assign reg_rd_stb  = load_evt && in_bank;
  assign reg_rd_addr = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      shreg     <= 8'd0;
      bitcnt    <= 4'd0;
      sda_oe    <= 1'b0;
      mack      <= 1'b0;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      bitcnt <= 4'd0;
      sda_oe <= 1'b0;
    end else if (stop_evt) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= 4'd0;
            if (state == ST_ADDR && !addr_hit) begin
              state <= ST_IGNORE;
            end else begin
              state  <= ST_ACK;
              sda_oe <= 1'b1;
              if (state == ST_ADDR) after_ack <= shreg[0] ? ST_SEND : ST_PTR;
              else                  after_ack <= ST_WDATA;
            end
          end
        end
        ST_ACK, ST_MACK: begin
          if (scl_rise && state == ST_MACK) begin
            mack <= ~sda_s;
          end else if (load_evt) begin
            shreg  <= load_val;
            sda_oe <= ~load_val[7];
            bitcnt <= 4'd0;
            state  <= ST_SEND;
          end else if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= (state == ST_ACK) ? after_ack : ST_IGNORE;
          end
        end
        ST_SEND: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == BYTE_LEN) begin
              sda_oe <= 1'b0;
              bitcnt <= 4'd0;
              state  <= ST_MACK;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              sda_oe <= ~shreg[6];
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int unsigned NUM_REGS = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       sda_oe,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       quiet,
  input logic       ptr_set,
  input logic       load_evt,
  input logic [7:0] ptr,
  input logic       reg_wr_en,
  input logic [7:0] reg_wr_addr,
  input logic       reg_rd_stb,
  input logic [7:0] reg_rd_addr
);
  localparam logic [7:0] BANK_SZ = 8'(NUM_REGS);

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || $past(start_evt || stop_evt))); // R4

  AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !sda_oe); // R9

  AST_WR_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> (reg_wr_addr < BANK_SZ)); // R7

  AST_RDSTB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_stb |=> !reg_rd_stb); // R10

  AST_RDSTB_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_stb |-> (reg_rd_addr < BANK_SZ)); // R10

  AST_PTR_KEPT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> $stable(ptr)); // R6

  AST_PTR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr >= BANK_SZ) |=> ((ptr >= BANK_SZ) || $past(ptr_set))); // R8

  AST_LOAD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && (ptr < BANK_SZ)) |=> (ptr == $past(ptr) + 8'd1)); // R5
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .quiet(quiet),
  .ptr_set(ptr_set), .load_evt(load_evt), .ptr(ptr),
  .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
  .reg_rd_stb(reg_rd_stb), .reg_rd_addr(reg_rd_addr)
);

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;
  localparam logic [6:0] DEV = 7'h2A;
  localparam int NREG = 4;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_oe, reg_wr_en, reg_rd_stb;
  logic [7:0] reg_wr_addr, reg_wr_data, reg_rd_addr, reg_rd_data;

  logic [7:0] regs [NREG];
  logic [7:0] exp_regs [NREG];
  logic [7:0] rbuf [8];
  int checks = 0, failures = 0;
  int wr_cnt = 0, stb_cnt = 0, unstable = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_reg_target u_i2c_reg_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_stb(reg_rd_stb), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
  );

  assign reg_rd_data = (reg_rd_addr < NREG) ? regs[reg_rd_addr[1:0]] : 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= 8'hA0 + 8'(i);
    end else if (reg_wr_en) begin
      regs[reg_wr_addr[1:0]] <= reg_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (rst_n && reg_rd_stb) stb_cnt <= stb_cnt + 1;
  end

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p < NREG) ? p + 8'd1 : p;
  endfunction

  function automatic logic [7:0] expv(input logic [7:0] p);
    return (p < NREG) ? exp_regs[p[1:0]] : 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic tq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    m_sda = 1'b1; tq(); scl = 1'b1; tq(); m_sda = 1'b0; tq(); scl = 1'b0; tq();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; tq(); scl = 1'b1; tq(); m_sda = 1'b1; tq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tq(); scl = 1'b1; tq(); tq(); scl = 1'b0; tq();
    end
    m_sda = 1'b1; tq(); scl = 1'b1; tq(); ack = ~sda_line; tq(); scl = 1'b0; tq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; tq(); scl = 1'b1; tq(); s1 = sda_line; tq(); s2 = sda_line;
      if (s1 !== s2) unstable++;
      d[i] = s2; scl = 1'b0; tq();
    end
    m_sda = ~give_ack; tq(); scl = 1'b1; tq(); tq(); scl = 1'b0; tq();
  endtask

  task automatic write_frame(input logic [7:0] p, input int n, input logic [7:0] base,
                             input string tag);
    logic a;
    do_start();
    send_byte({DEV, 1'b0}, a); chk({tag, " addr ack"}, a, 1);
    send_byte(p, a);           chk({tag, " ptr ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(base + 8'(k), a); chk({tag, " data ack"}, a, 1);
    end
    do_stop();
  endtask

  task automatic read_frame(input logic set_p, input logic [7:0] p, input int n,
                            input string tag);
    logic a;
    do_start();
    if (set_p) begin
      send_byte({DEV, 1'b0}, a); chk({tag, " waddr ack"}, a, 1);
      send_byte(p, a);           chk({tag, " ptr ack"}, a, 1);
      do_start();
    end
    send_byte({DEV, 1'b1}, a); chk({tag, " raddr ack"}, a, 1);
    for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
    do_stop();
  endtask

  initial begin
    logic [7:0] p, d;
    logic a;
    int w0, s0, ew, es;
    for (int i = 0; i < NREG; i++) exp_regs[i] = 8'hA0 + 8'(i);
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset wr_en", reg_wr_en, 0);
    chk("R1 reset rd_stb", reg_rd_stb, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: byte clocked with no start condition is not acknowledged
    scl = 1'b0; tq();
    send_byte({DEV, 1'b0}, a); chk("R1 no-start no ack", a, 0);
    scl = 1'b1; tq(); do_stop(); tq();

    // R6: pointer is 0 after reset; read without pointer byte
    read_frame(1'b0, 8'h00, 1, "R6 reset ptr");
    chk("R6 first read from reg0", rbuf[0], 8'hA0);
    p = 8'd1;

    // Sweep of start pointers: R3 R5 R6 R7 R8 R10
    for (int sp = 0; sp < NREG + 2; sp++) begin
      w0 = wr_cnt; ew = 0;
      write_frame(8'(sp), 3, 8'(16 * sp + 1), "R3 sweep write");
      p = 8'(sp);
      for (int k = 0; k < 3; k++) begin
        if (p < NREG) begin exp_regs[p[1:0]] = 8'(16 * sp + 1 + k); ew++; end
        p = nxt(p);
      end
      chk("R7 write pulses only in bank", wr_cnt - w0, ew);
      s0 = stb_cnt; es = 0;
      read_frame(1'b1, 8'(sp), 6, "R5 sweep read");
      p = 8'(sp);
      for (int k = 0; k < 6; k++) begin
        chk("R5 R7 sequential read", rbuf[k], expv(p));
        if (p < NREG) es++;
        p = nxt(p);
      end
      chk("R10 read strobe count", stb_cnt - s0, es);
      read_frame(1'b0, 8'h00, 2, "R6 resume");
      for (int k = 0; k < 2; k++) begin
        chk("R6 R8 resume after stop", rbuf[k], expv(p));
        p = nxt(p);
      end
    end

    // R2: wrong device address is ignored
    w0 = wr_cnt;
    do_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a); chk("R2 mismatch no ack", a, 0);
    send_byte(8'h00, a); chk("R2 mismatch ptr no ack", a, 0);
    send_byte(8'h55, a); chk("R2 mismatch data no ack", a, 0);
    do_stop();
    chk("R2 mismatch no writes", wr_cnt - w0, 0);
    read_frame(1'b0, 8'h00, 1, "R2 ptr kept");
    chk("R2 pointer unchanged after mismatch", rbuf[0], expv(p));

    // R9: NACK then more clocking: target stays off the line
    read_frame(1'b1, 8'h01, 2, "R9 setup");
    chk("R9 setup data", rbuf[0], exp_regs[1]);
    do_start();
    send_byte({DEV, 1'b0}, a); send_byte(8'h00, a);
    do_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(1'b0, d); chk("R9 byte before nack", d, exp_regs[0]);
    recv_byte(1'b0, d); chk("R9 released after nack", d, 8'hFF);
    do_stop();

    // R8: pointer FFh, writes do not wrap into register 0
    w0 = wr_cnt;
    write_frame(8'hFF, 3, 8'h11, "R8 top write");
    chk("R8 no write past top", wr_cnt - w0, 0);
    read_frame(1'b0, 8'h00, 2, "R8 top read");
    chk("R8 stays in filler 0", rbuf[0], 8'hFF);
    chk("R8 stays in filler 1", rbuf[1], 8'hFF);
    read_frame(1'b1, 8'h00, 1, "R8 reg0 intact");
    chk("R8 reg0 intact", rbuf[0], exp_regs[0]);

    // R4: bits stable during SCL high throughout the run
    chk("R4 read bits stable while SCL high", unstable, 0);
    chk("R1 line released at end", sda_oe, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog got=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule